// File: doc/BRIEF.md
# Flash In-Application Command Sequencer

This block gives a processor a small window of byte-wide registers through which it can read, program and erase a non-volatile data area while the application runs. The processor fills in an address (two bytes), a data byte and a command code. It writes the enable value into the control register. It then writes a two-byte key to the trigger register. Only a correct key, given while the block is enabled and idle, starts the operation. The storage is modelled inside the block as a byte array that reads back erased (all ones).

Programming follows flash rules: a program operation can only turn ones into zeros. Erase returns a whole sector to all ones. Program and erase hold a busy flag for a fixed, parameterised number of cycles and commit their effect when busy falls. A read places the addressed byte in the data register a fixed two cycles after the trigger completes. A sticky error flag records rejected trigger attempts and clears on any write to the control register.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the control, command, data, address-high and address-low registers read 0x00, busy and err are low, and every stored byte reads 0xFF.
- R2: A trigger-register write made while idle with the control register not equal to 0x81 starts no operation, leaves busy low and sets err.
- R3: An operation starts only on a trigger write of 0xA5 whose previous trigger write was 0x5A. A 0x5A write always arms the key, including when it is already armed. Any other trigger value, or 0xA5 while unarmed, disarms the key, starts nothing and sets err.
- R4: A program or erase raises busy at the clock edge that accepts the 0xA5 write and holds it for exactly BUSY_CYCLES cycles. While busy, trigger writes are ignored: they do not arm, start or set err. The operation uses the command, address and data captured when it started.
- R5: Any write to the control register (select 0) clears err.
- R6: Command 0x01 (read) leaves busy low. The data register keeps its old value one cycle after the accepting edge and holds the stored byte from the second edge after it.
- R7: Command 0x02 (program) replaces the addressed byte with the bitwise AND of its old value and the data register.
- R8: Command 0x03 (erase) sets all SECTOR_BYTES bytes of the sector holding the address to 0xFF and leaves other sectors unchanged.
- R9: Command 0x00 and every code above 0x03 change no stored byte, leave busy low, leave the data register unchanged and do not set err.
- R10: The byte address is the low log2(MEM_BYTES) bits of {address-high, address-low}, and higher bits are ignored. The registers are selected as control 0, command 1, trigger 2, data 3, address-high 4, address-low 5. Reads of selects 2, 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| sel | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Sticky rejected-trigger flag |

## Verification
The assertions assume one register access per cycle on a single bus, so a trigger write and a control write never coincide. They also assume that busy can only start from a key accepted while idle. The stimulus keeps to this because every access goes through one write task that drives a single select per cycle. Random commands, addresses with random upper address-high bits and random data are mixed with directed key errors, disabled triggers and trigger writes issued during busy. Each result is compared against a byte model kept in the bench.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   localparam logic [2:0] RS_CTRL = 3'd0;
   localparam logic [2:0] RS_CMD  = 3'd1;
   localparam logic [2:0] RS_TRIG = 3'd2;
   localparam logic [2:0] RS_DATA = 3'd3;
   localparam logic [2:0] RS_AHI  = 3'd4;
   localparam logic [2:0] RS_ALO  = 3'd5;

   localparam logic [7:0] CTRL_ENABLE = 8'h81;
   localparam logic [7:0] KEY_FIRST   = 8'h5A;
   localparam logic [7:0] KEY_SECOND  = 8'hA5;
   localparam logic [7:0] BYTE_ERASED = 8'hFF;

   localparam logic [7:0] OP_NOP   = 8'h00;
   localparam logic [7:0] OP_READ  = 8'h01;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_ERASE = 8'h03;
endpackage

// File: rtl/flash_unlock.sv
module flash_unlock
   import flash_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_wr,
   input  logic [7:0] trig_val,
   input  logic       enabled,
   input  logic       busy,
   output logic       fire,
   output logic       bad
);
   logic armed_q, armed_d;

   always_comb begin
      fire    = 1'b0;
      bad     = 1'b0;
      armed_d = armed_q;
      if (trig_wr && !busy) begin
         if (!enabled) begin
            bad     = 1'b1;
            armed_d = 1'b0;
         end else if (trig_val == KEY_FIRST) begin
            armed_d = 1'b1;
         end else if (trig_val == KEY_SECOND && armed_q) begin
            fire    = 1'b1;
            armed_d = 1'b0;
         end else begin
            bad     = 1'b1;
            armed_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_d;
   end

   AST_FIRE_OR_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && bad)) else $error("fire and bad together"); // R3
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
   parameter int BUSY_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   logic busy_q;
   assign busy = busy_q;

   generate
      if (BUSY_CYCLES == 1) begin : g_single
         assign done = busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     busy_q <= 1'b0;
            else if (start) busy_q <= 1'b1;
            else            busy_q <= 1'b0;
         end
         AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            busy_q |=> !busy_q) else $error("busy longer than one cycle"); // R4
      end else begin : g_count
         localparam int CW = $clog2(BUSY_CYCLES);
         localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);
         logic [CW-1:0] cnt_q;
         assign done = busy_q && (cnt_q == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else if (start) begin
               busy_q <= 1'b1;
               cnt_q  <= LOAD;
            end else if (done) begin
               busy_q <= 1'b0;
            end else if (busy_q) begin
               cnt_q  <= cnt_q - 1'b1;
            end
         end
         AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q && cnt_q != '0) |=> busy_q) else $error("busy dropped early"); // R4
      end
   endgenerate
endmodule

// File: rtl/flash_store.sv
module flash_store
   import flash_seq_pkg::*;
#(
   parameter int MEM_BYTES    = 1024,
   parameter int SECTOR_BYTES = 512,
   localparam int AW = $clog2(MEM_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_en,
   input  logic          erase_en,
   input  logic [AW-1:0] op_addr,
   input  logic [7:0]    op_val,
   output logic [7:0]    rd_val
);
   logic [7:0] mem [MEM_BYTES];

   assign rd_val = mem[op_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= BYTE_ERASED;
      end else begin
         for (int i = 0; i < MEM_BYTES; i++) begin
            if (erase_en && (i / SECTOR_BYTES) == (int'(op_addr) / SECTOR_BYTES))
               mem[i] <= BYTE_ERASED;
            else if (prog_en && i == int'(op_addr))
               mem[i] <= mem[i] & op_val;
         end
      end
   end

   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_en && erase_en)) else $error("program and erase together"); // R7
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_seq_pkg::*;
#(
   parameter int MEM_BYTES    = 1024,
   parameter int SECTOR_BYTES = 512,
   parameter int BUSY_CYCLES  = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] sel,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       busy,
   output logic       err
);
   localparam int AW = $clog2(MEM_BYTES);

   generate
      if (MEM_BYTES < 2 || MEM_BYTES > 65536 || (1 << AW) != MEM_BYTES) begin : g_bad_mem
         $error("MEM_BYTES must be a power of two from 2 to 65536");
      end
      if (SECTOR_BYTES < 1 || SECTOR_BYTES > MEM_BYTES ||
          (1 << $clog2(SECTOR_BYTES)) != SECTOR_BYTES) begin : g_bad_sector
         $error("SECTOR_BYTES must be a power of two not above MEM_BYTES");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least one");
      end
   endgenerate

   logic [7:0]    ctrl_q, cmd_q, data_q, ahi_q, alo_q;
   logic [7:0]    op_cmd_q, op_data_q;
   logic [AW-1:0] op_addr_q;
   logic          rd_p1_q, rd_p2_q;
   logic          fire, bad, done, start_long, err_q;
   logic [7:0]    rd_val;

   wire ctrl_wr = wr_en && (sel == RS_CTRL);
   wire trig_wr = wr_en && (sel == RS_TRIG);
   wire enabled = (ctrl_q == CTRL_ENABLE);

   flash_unlock u_unlock (
      .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .trig_val(wdata),
      .enabled(enabled), .busy(busy), .fire(fire), .bad(bad)
   );

   assign start_long = fire && (cmd_q == OP_PROG || cmd_q == OP_ERASE);

   flash_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_long), .busy(busy), .done(done)
   );

   flash_store #(.MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .prog_en(done && op_cmd_q == OP_PROG),
      .erase_en(done && op_cmd_q == OP_ERASE),
      .op_addr(op_addr_q), .op_val(op_data_q), .rd_val(rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0; cmd_q <= '0; ahi_q <= '0; alo_q <= '0;
      end else if (wr_en) begin
         case (sel)
            RS_CTRL: ctrl_q <= wdata;
            RS_CMD:  cmd_q  <= wdata;
            RS_AHI:  ahi_q  <= wdata;
            RS_ALO:  alo_q  <= wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_cmd_q <= '0; op_data_q <= '0; op_addr_q <= '0;
      end else if (fire) begin
         op_cmd_q  <= cmd_q;
         op_data_q <= data_q;
         op_addr_q <= AW'({ahi_q, alo_q});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p1_q <= 1'b0; rd_p2_q <= 1'b0; data_q <= '0;
      end else begin
         rd_p1_q <= fire && (cmd_q == OP_READ);
         rd_p2_q <= rd_p1_q;
         if (rd_p2_q)                      data_q <= rd_val;
         else if (wr_en && sel == RS_DATA) data_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (ctrl_wr) err_q <= 1'b0;
      else if (bad)     err_q <= 1'b1;
   end
   assign err = err_q;

   always_comb begin
      case (sel)
         RS_CTRL: rdata = ctrl_q;
         RS_CMD:  rdata = cmd_q;
         RS_DATA: rdata = data_q;
         RS_AHI:  rdata = ahi_q;
         RS_ALO:  rdata = alo_q;
         default: rdata = 8'h00;
      endcase
   end

   AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig_wr && ctrl_q != CTRL_ENABLE) |=> !busy) else $error("start while disabled"); // R2
   AST_DISABLED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig_wr && ctrl_q != CTRL_ENABLE) |=> err) else $error("err not set"); // R2
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> !err) else $error("err not cleared"); // R5
   AST_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !busy) else $error("start while busy"); // R4
   AST_READ_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_q == OP_READ) |=> !busy) else $error("read raised busy"); // R6
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
   localparam int MEM  = 1024;
   localparam int SECT = 512;
   localparam int BUSY = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] sel_i = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       busy, err;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [MEM];

   always #2 clk = ~clk;

   flash_cmd_seq #(.MEM_BYTES(MEM), .SECTOR_BYTES(SECT), .BUSY_CYCLES(BUSY)) u_flash_cmd_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel_i), .wdata(wdata),
      .rdata(rdata), .busy(busy), .err(err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [2:0] s, input logic [7:0] v);
      wr_en = 1'b1; sel_i = s; wdata = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input logic [2:0] s, output logic [7:0] v);
      sel_i = s;
      #1;
      v = rdata;
   endtask

   function automatic logic [9:0] baddr(input logic [7:0] hi, input logic [7:0] lo);
      return {hi[1:0], lo};
   endfunction

   task automatic model_prog(input logic [9:0] a, input logic [7:0] d);
      model[a] = model[a] & d;
   endtask

   task automatic model_erase(input logic [9:0] a);
      for (int i = 0; i < MEM; i++)
         if (i / SECT == int'(a) / SECT) model[i] = 8'hFF;
   endtask

   task automatic do_op(input logic [7:0] op, input logic [7:0] hi, input logic [7:0] lo,
                        input logic [7:0] dv);
      logic [7:0] v;
      logic [9:0] a;
      int n;
      a = baddr(hi, lo);
      wr(3'd0, 8'h81); wr(3'd4, hi); wr(3'd5, lo); wr(3'd3, dv); wr(3'd1, op);
      wr(3'd2, 8'h5A); wr(3'd2, 8'hA5);
      if (op == 8'h01) begin
         check(busy == 1'b0, "R6 read busy", busy, 0);
         @(negedge clk);
         peek(3'd3, v);
         check(v == dv, "R6 data early", v, dv);
         @(negedge clk);
         peek(3'd3, v);
         check(v == model[a], "R6 R10 read value", v, model[a]);
      end else if (op == 8'h02 || op == 8'h03) begin
         n = 0;
         while (busy) begin n++; @(negedge clk); end
         check(n == BUSY, "R4 busy length", n, BUSY);
         if (op == 8'h02) model_prog(a, dv); else model_erase(a);
         check(err == 1'b0, "R4 err", err, 0);
      end else begin
         repeat (3) @(negedge clk);
         check(busy == 1'b0, "R9 busy", busy, 0);
         peek(3'd3, v);
         check(v == dv, "R9 data", v, dv);
         check(err == 1'b0, "R9 err", err, 0);
      end
   endtask

   task automatic verify(input logic [9:0] a, input string tag);
      logic [7:0] v;
      do_op(8'h01, {6'd0, a[9:8]}, a[7:0], 8'h00);
      peek(3'd3, v);
      check(v == model[a], tag, v, model[a]);
   endtask

   initial begin
      logic [7:0] v, hi, lo, dv, op;
      int n;
      void'($urandom(32'h5EED1234));
      for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 6; s++) begin
         peek(3'(s), v);
         check(v == 8'h00, "R1 register reset", v, 0);
      end
      check(busy == 1'b0 && err == 1'b0, "R1 flags reset", {busy, err}, 0);
      verify(10'h2C7, "R1 erased byte");

      // R10 readback and unused selects
      wr(3'd4, 8'hC3); wr(3'd5, 8'h3C);
      peek(3'd4, v); check(v == 8'hC3, "R10 ahi readback", v, 8'hC3);
      peek(3'd5, v); check(v == 8'h3C, "R10 alo readback", v, 8'h3C);
      peek(3'd2, v); check(v == 8'h00, "R10 trig reads zero", v, 0);
      peek(3'd6, v); check(v == 8'h00, "R10 select 6", v, 0);

      // R7 program clears bits only; R10 address wrap
      do_op(8'h02, 8'h84, 8'h21, 8'h0F);
      verify(10'h021, "R7 R10 program wrap");
      do_op(8'h02, 8'h00, 8'h21, 8'hF3);
      verify(10'h021, "R7 and-in");
      do_op(8'h02, 8'h02, 8'h10, 8'h55);

      // R8 erase one sector only
      do_op(8'h03, 8'h03, 8'hFF, 8'h00);
      verify(10'h210, "R8 erased sector");
      verify(10'h021, "R8 other sector kept");

      // R2 disabled trigger
      wr(3'd0, 8'h01); wr(3'd1, 8'h03); wr(3'd2, 8'h5A); wr(3'd2, 8'hA5);
      check(busy == 1'b0, "R2 no start", busy, 0);
      check(err == 1'b1, "R2 err set", err, 1);
      wr(3'd0, 8'h81);
      check(err == 1'b0, "R5 err cleared", err, 0);
      verify(10'h021, "R2 nothing erased");

      // R3 bad key order
      wr(3'd4, 8'h00); wr(3'd5, 8'h21); wr(3'd3, 8'h00); wr(3'd1, 8'h02);
      wr(3'd2, 8'h5A); wr(3'd2, 8'h33);
      check(err == 1'b1, "R3 bad value err", err, 1);
      wr(3'd2, 8'hA5);
      check(busy == 1'b0, "R3 unarmed A5 no start", busy, 0);
      wr(3'd0, 8'h81);
      wr(3'd2, 8'hA5);
      check(err == 1'b1 && busy == 1'b0, "R3 lone A5", {busy, err}, 1);
      verify(10'h021, "R3 byte untouched");

      // R3 double 5A still arms
      wr(3'd0, 8'h81); wr(3'd4, 8'h01); wr(3'd5, 8'h08); wr(3'd3, 8'h3C); wr(3'd1, 8'h02);
      wr(3'd2, 8'h5A); wr(3'd2, 8'h5A); wr(3'd2, 8'hA5);
      check(busy == 1'b1 && err == 1'b0, "R3 rearm start", {busy, err}, 2);
      model_prog(10'h108, 8'h3C);
      // R4 triggers during busy are ignored, operands captured at start
      wr(3'd1, 8'h03); wr(3'd2, 8'h5A); wr(3'd2, 8'hA5);
      check(err == 1'b0, "R4 busy trigger no err", err, 0);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      check(busy == 1'b0, "R4 no queued start", busy, 0);
      verify(10'h108, "R4 captured program");
      verify(10'h021, "R4 no erase ran");

      // R9 nop and unknown code
      do_op(8'h00, 8'h00, 8'h21, 8'h77);
      do_op(8'h9C, 8'h00, 8'h21, 8'h66);
      verify(10'h021, "R9 byte unchanged");

      // random mix
      for (int k = 0; k < 80; k++) begin
         n  = $urandom % 16;
         hi = 8'($urandom); lo = 8'($urandom); dv = 8'($urandom);
         if (n < 6)       op = 8'h01;
         else if (n < 11) op = 8'h02;
         else if (n < 12) op = 8'h03;
         else if (n < 14) op = 8'h00;
         else             op = 8'(4 + $urandom % 252);
         do_op(op, hi, lo, dv);
         if (op == 8'h02) verify(baddr(hi, lo), "R7 random program");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule